// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block watches load and store transfers on a 32-bit big-endian local data bus and signals when a transfer's operand matches a programmed breakpoint value. It holds two independent value/mask register pairs. Any mask bit that is set removes the matching value bit from the comparison.

For every qualified transfer, the block uses the two low address bits and the access size to pull the operand out of the correct byte lanes. Misaligned byte and word references are handled. The operand is zero-extended and compared against the low-order byte, halfword or word of each value register, under the same low-order part of the mask. Each pair then produces a registered hit pulse.

Debug software writes and reads the four registers through a small port indexed by a 5-bit register code. The result feeds a trigger sequencer elsewhere in the chip.

Top module: `data_bkpt_cmp`

## Requirements
- R1: The register codes are 5'h0E for value 0, 5'h1E for value 1, 5'h0F for mask 0 and 5'h1F for mask 1. A write (`reg_we` high at a clock edge) to one of these codes loads `reg_wdata`. `reg_rdata` shows the addressed register combinationally, and the value of a write appears from the cycle after that write.
- R2: A write to any other code changes no register. A read of any other code returns zero.
- R3: Where a mask bit is 1, the matching value bit is excluded from the comparison. Where a mask bit is 0, the value bit must equal the operand bit.
- R4: Byte access (`bus_size`=2'b00) takes its operand from these lanes: `bus_addr`=00 gives data[31:24], 01 gives data[23:16], 10 gives data[15:8] and 11 gives data[7:0].
- R5: Word access (`bus_size`=2'b01) takes data[31:16] when `bus_addr[1]`=0 and data[15:0] when `bus_addr[1]`=1. `bus_addr[0]` has no effect.
- R6: Longword access (`bus_size`=2'b10) compares all of data[31:0], whatever `bus_addr` holds.
- R7: The operand is compared only against value and mask bits [7:0] for a byte and bits [15:0] for a word. Higher value and mask bits have no effect.
- R8: No hit is produced for a cycle with `bus_valid` low, or for the reserved size code 2'b11.
- R9: `hit[i]` goes high for exactly the one cycle after a qualifying matching transfer on pair i. The two pairs are evaluated independently.
- R10: While `rst_n` is low and in the first cycle after it, `hit` is zero. The value and mask registers have no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the hit outputs |
| reg_we | input | 1 | Register write strobe |
| reg_code | input | 5 | Register code for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| bus_valid | input | 1 | Data-valid strobe for the current transfer |
| bus_addr | input | 2 | Low address bits of the transfer |
| bus_size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| bus_data | input | 32 | Local data bus |
| hit | output | 2 | Registered hit pulse per pair |

## Verification
The hardest case to reach is a hit on a narrow lane in which every unmasked low-order bit matches while the value register's upper bits disagree with the bus. Random bus data almost never matches.

The stimulus therefore copies the low-order part of a value register into the lane selected by the address and size on about half of the transfers. It then flips random bits that the mask hides. Between bursts it reprograms the registers with random values and sparse random masks.

Directed transfers vary `bus_addr[0]` on word accesses and every address on longword accesses, so that ignored address bits are exercised.

// File: rtl/data_bkpt_cmp.sv
module data_bkpt_cmp #(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [CW-1:0] reg_code,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [1:0]    bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] bus_data,
  output logic [1:0]    hit
);
  localparam int NP = 2;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  logic [DW-1:0] val_q [NP];
  logic [DW-1:0] msk_q [NP];
  logic [DW-1:0] operand, lane_mask;
  logic          size_ok;
  logic [NP-1:0] hit_d, hit_q;

  always_comb begin
    operand   = '0;
    lane_mask = '0;
    size_ok   = 1'b1;
    case (bus_size)
      SZ_BYTE: begin
        lane_mask = DW'(8'hFF);
        case (bus_addr)
          2'b00:   operand = DW'(bus_data[31:24]);
          2'b01:   operand = DW'(bus_data[23:16]);
          2'b10:   operand = DW'(bus_data[15:8]);
          default: operand = DW'(bus_data[7:0]);
        endcase
      end
      SZ_WORD: begin
        lane_mask = DW'(16'hFFFF);
        operand   = bus_addr[1] ? DW'(bus_data[15:0]) : DW'(bus_data[31:16]);
      end
      SZ_LONG: begin
        lane_mask = '1;
        operand   = bus_data;
      end
      default: size_ok = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NP; i++) begin : g_pair
    localparam logic [CW-1:0] VCODE = CW'(5'h0E | (i << 4));
    localparam logic [CW-1:0] MCODE = CW'(5'h0F | (i << 4));

    always_ff @(posedge clk) begin
      if (reg_we && reg_code == VCODE) val_q[i] <= reg_wdata;
      if (reg_we && reg_code == MCODE) msk_q[i] <= reg_wdata;
    end

    assign hit_d[i] = bus_valid && size_ok &&
                      (((operand ^ val_q[i]) & ~msk_q[i] & lane_mask) == '0);
  end

  always_comb begin
    case (reg_code)
      CW'(5'h0E): reg_rdata = val_q[0];
      CW'(5'h0F): reg_rdata = msk_q[0];
      CW'(5'h1E): reg_rdata = val_q[1];
      CW'(5'h1F): reg_rdata = msk_q[1];
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;
endmodule

// File: rtl/data_bkpt_cmp_chk.sv
module data_bkpt_cmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [4:0]  reg_code,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        bus_valid,
  input logic [1:0]  bus_size,
  input logic [31:0] msk0,
  input logic [1:0]  hit
);
  function automatic logic is_known(input logic [4:0] c);
    return c == 5'h0E || c == 5'h0F || c == 5'h1E || c == 5'h1F;
  endfunction

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && is_known(reg_code)) |=> (reg_code != $past(reg_code) || reg_rdata == $past(reg_wdata))); // R1
  AST_UNKNOWN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !is_known(reg_code) |-> reg_rdata == '0); // R2
  AST_FULL_MASK_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != 2'b11 && msk0 == '1) |=> hit[0]); // R3
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> hit == '0); // R8
  AST_RESERVED_SIZE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size == 2'b11) |=> hit == '0); // R8
  AST_RESET_CLEARS_HIT: assert property (@(posedge clk)
    !rst_n |=> hit == '0); // R10
endmodule

bind data_bkpt_cmp data_bkpt_cmp_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_code(reg_code),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
  .bus_size(bus_size), .msk0(msk_q[0]), .hit(hit)
);

// File: tb/test_data_bkpt_cmp.sv
module test_data_bkpt_cmp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_code;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bus_valid;
  logic [1:0]  bus_addr, bus_size;
  logic [31:0] bus_data;
  logic [1:0]  hit;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_val [2];
  logic [31:0] m_msk [2];
  bit [3:0] known = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_bkpt_cmp i_data_bkpt_cmp (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_code(reg_code),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_data(bus_data), .hit(hit)
  );

  function automatic int reg_idx(input logic [4:0] c);
    case (c)
      5'h0E: return 0;
      5'h0F: return 1;
      5'h1E: return 2;
      5'h1F: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int k);
    case (k)
      0: return m_val[0];
      1: return m_msk[0];
      2: return m_val[1];
      3: return m_msk[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit model_hit(input int p, input bit v, input int a, input int sz, input logic [31:0] d);
    longint unsigned op, lm;
    if (!v || sz == 3) return 0;
    if (sz == 0) begin op = (d >> (8 * (3 - a))) % 256; lm = 255; end
    else if (sz == 1) begin op = (a >= 2) ? d % 65536 : d / 65536; lm = 65535; end
    else begin op = d; lm = 64'hFFFF_FFFF; end
    return ((op ^ m_val[p]) & ~longint'(m_msk[p]) & lm) == 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [4:0] code, input logic [31:0] wd,
                      input bit v, input int a, input int sz, input logic [31:0] d, input string tag);
    int k;
    logic [1:0] eh;
    reg_we = we; reg_code = code; reg_wdata = wd;
    bus_valid = v; bus_addr = 2'(a); bus_size = 2'(sz); bus_data = d;
    #1;
    k = reg_idx(code);
    if (k < 0) check("R2 read unknown", reg_rdata, 32'h0);
    else if (known[k]) check("R1 readback", reg_rdata, model_read(k));
    eh = {model_hit(1, v, a, sz, d), model_hit(0, v, a, sz, d)};
    if (!rst_n) eh = 2'b00;
    @(posedge clk);
    if (we && k >= 0) begin
      known[k] = 1'b1;
      case (k)
        0: m_val[0] = wd;
        1: m_msk[0] = wd;
        2: m_val[1] = wd;
        default: m_msk[1] = wd;
      endcase
    end
    @(negedge clk);
    check(tag, {30'h0, hit}, {30'h0, eh});
  endtask

  task automatic wr(input logic [4:0] code, input logic [31:0] wd);
    step(1'b1, code, wd, 1'b0, 0, 0, 32'h0, "R8 idle during write");
  endtask

  task automatic xfer(input int a, input int sz, input logic [31:0] d, input string tag);
    step(1'b0, 5'h0E, 32'h0, 1'b1, a, sz, d, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    reg_we = 0; reg_code = 5'h00; reg_wdata = 0;
    bus_valid = 1; bus_addr = 0; bus_size = 2; bus_data = 0;
    @(negedge clk);
    step(0, 5'h00, 0, 1, 0, 2, 32'h0, "R10 hit held low in reset");
    step(0, 5'h00, 0, 1, 0, 2, 32'h0, "R10 hit held low in reset");
    rst_n = 1'b1;
    step(0, 5'h00, 0, 0, 0, 0, 0, "R10 hit low after reset");

    wr(5'h0E, 32'hFFFF_FF5A); wr(5'h0F, 32'h00FF_FF00);
    wr(5'h1E, 32'h1234_5678); wr(5'h1F, 32'h0000_0000);
    wr(5'h10, 32'hDEAD_BEEF); wr(5'h0D, 32'hCAFE_F00D);
    foreach (known[k]) step(0, (k==0)?5'h0E:(k==1)?5'h0F:(k==2)?5'h1E:5'h1F, 0, 0, 0, 0, 0, "R2 no change after unknown write");

    xfer(0, 0, 32'h5A00_0000, "R4 byte lane 0 R7");
    xfer(1, 0, 32'h005A_0000, "R4 byte lane 1");
    xfer(2, 0, 32'h0000_5A00, "R4 byte lane 2");
    xfer(3, 0, 32'h0000_005A, "R4 byte lane 3");
    xfer(3, 0, 32'h0000_005B, "R3 byte mismatch");
    xfer(0, 1, 32'h5678_0000, "R5 word upper");
    xfer(1, 1, 32'h5678_0000, "R5 word upper a0 ignored");
    xfer(3, 1, 32'h0000_5678, "R5 word lower a0 ignored");
    xfer(2, 1, 32'h5678_0000, "R5 word lower mismatch");
    for (int a = 0; a < 4; a++) xfer(a, 2, 32'h1234_5678, "R6 long any address");
    xfer(0, 3, 32'h1234_5678, "R8 reserved size");
    step(0, 5'h0E, 0, 0, 0, 2, 32'h1234_5678, "R8 no valid");
    xfer(0, 2, 32'h1234_5678, "R9 back to back");
    xfer(0, 2, 32'h1234_5678, "R9 back to back");
    step(0, 5'h0E, 0, 0, 0, 2, 32'h1234_5678, "R9 pulse ends");

    wr(5'h0F, 32'hFFFF_FFFF);
    xfer(1, 0, 32'h0BAD_F00D, "R3 full mask hits");

    for (int it = 0; it < 1500; it++) begin
      if (it % 100 == 0) begin
        wr(5'h0E, $urandom); wr(5'h1E, $urandom);
        wr(5'h0F, $urandom & $urandom & $urandom);
        wr(5'h1F, $urandom & $urandom & $urandom);
      end
      begin
        int a, sz, p;
        logic [31:0] d;
        a = $urandom_range(0, 3); sz = $urandom_range(0, 3); p = $urandom_range(0, 1);
        d = $urandom;
        if ($urandom_range(0, 1) == 1) begin
          if (sz == 0) d[8*(3-a) +: 8] = m_val[p][7:0] ^ (m_msk[p][7:0] & 8'($urandom));
          else if (sz == 1) begin
            if (a >= 2) d[15:0] = m_val[p][15:0] ^ (m_msk[p][15:0] & 16'($urandom));
            else d[31:16] = m_val[p][15:0] ^ (m_msk[p][15:0] & 16'($urandom));
          end
          else d = m_val[p] ^ (m_msk[p] & $urandom);
        end
        step(0, 5'($urandom), 0, $urandom_range(0, 4) != 0, a, sz, d,
             (sz == 0) ? "R4 R7 random byte" : (sz == 1) ? "R5 R7 random word" :
             (sz == 2) ? "R6 R3 random long" : "R8 random reserved");
      end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule